// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte-Lane Writes

A behavioural, synthesizable single-port synchronous SRAM. Its word is four 9-bit byte lanes, and its depth is set by an address-width parameter. Every address, data, enable, strobe and write-control input is captured on the rising clock edge. The output-enable and sleep inputs act on the output at once, without waiting for a clock edge. The block is built for a host that issues single accesses or short bursts of four words. A dedicated child module generates the burst address from the two low address bits, in either linear or interleaved order.

An access begins when one of two active-low address strobes is asserted. The primary strobe is honoured only while the first chip enable is low, and it always opens a read. The secondary strobe opens a read or a write, chosen by the write controls. Between strobes the host may advance the burst or hold the address. Writes cover either every lane (global write) or a chosen subset of lanes (byte write). A mode input picks the read path. In flow-through mode, data comes straight from the array in the cycle after the address. In pipelined mode, data passes through an output register and appears one cycle later.

A strobe that arrives while the chip is not selected ends the current burst. The output then stops driving after a single cycle. Sleep freezes all internal state and keeps the array contents. Reset clears the pipeline and the burst state but leaves the array untouched.

Top module: `syncBurstRam`

## Requirements
- R1: A low `adsc_n`, or a low `adsp_n` together with a low `cs1_n`, loads `addr` as the new access address when the chip is selected. While `cs1_n` is high, `adsp_n` is ignored: a cycle with only `adsp_n` low continues the current burst as if no strobe were given.
- R2: The chip is selected only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0 at the clock edge. A strobe in any other enable combination writes nothing and produces no read data.
- R3: A write cycle with `gw_n`=0 writes all four lanes, whatever the values of `bw_n` and `be_n`.
- R4: With `gw_n`=1 and `bw_n`=0, lane i (data bits 9i+8..9i) is written exactly when `be_n[i]`=0. All other lanes keep their contents.
- R5: A cycle opened by `adsp_n` is a read even when write controls are low. A write control in the following non-strobe cycle writes at the burst address of that cycle.
- R6: With `pipeMode`=0, read data and `dataOutEn`=1 appear in the clock cycle right after the edge that captured the address. Back-to-back loads give a new word every cycle.
- R7: With `pipeMode`=1, read data appears one cycle later than in R6.
- R8: With `linearBurst`=1, each cycle with `adv_n`=0 and no strobe moves to the next burst word. The two low address bits follow (start + n) mod 4, and the upper bits stay fixed.
- R9: With `linearBurst`=0, the two low address bits of burst word n are start XOR n.
- R10: In a non-strobe cycle with `adv_n`=1, the address is held and the same word is read again.
- R11: While `g_n`=1, `dataOutEn`=0 and `dataOut`=0, with no clock edge needed.
- R12: While `zz`=1, the output is not driven, no write or address change takes place, and the array keeps its contents. When `zz` falls, the access that was running resumes.
- R13: After a deselecting strobe, a flow-through output stops driving in the very next cycle. A pipelined output drives the last word for one more cycle and then stops.
- R14: Reset clears the read pipeline and the burst-active state (`dataOutEn`=0) and keeps the array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of control and pipeline state |
| addr | input | ADDR_W | External access address |
| dataIn | input | 36 | Write data, four 9-bit lanes |
| cs1_n | input | 1 | Chip enable 1, active low; also gates `adsp_n` |
| cs2 | input | 1 | Chip enable 2, active high |
| cs3_n | input | 1 | Chip enable 3, active low |
| adsp_n | input | 1 | Primary address strobe, active low, read-only start |
| adsc_n | input | 1 | Secondary address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bw_n | input | 1 | Byte-write enable, active low |
| be_n | input | 4 | Per-lane write enables, active low |
| g_n | input | 1 | Asynchronous output enable, active low |
| zz | input | 1 | Sleep, active high |
| pipeMode | input | 1 | 1 selects the registered read path, 0 flow-through |
| linearBurst | input | 1 | 1 selects linear burst order, 0 interleaved |
| dataOut | output | 36 | Read data, zero when not driven |
| dataOutEn | output | 1 | High when `dataOut` should drive the bus |

## Verification
The bench fills the whole array and reads every address back on both read paths. A design with a wrong latency returns the neighbouring word. It sweeps all sixteen byte-lane masks, plus a global write with every lane enable high; a design with a swapped or ignored lane merge corrupts the lanes that should have been kept. It runs bursts from all four start offsets in both orders. It also drives a primary strobe with `cs1_n` high, a write control on a primary-strobe cycle, every enable combination, sleep while write strobes are applied, and reset. These catch designs that wrap the wrong bits, deselect on a gated strobe, write on a read-only start, write while asleep or deselected, hold the pipelined output too long, or clear the array on reset.

// File: rtl/burstRamPkg.sv
package burstRamPkg;
  localparam int LANE_CNT  = 4;
  localparam int LANE_BITS = 9;
  localparam int WORD_BITS = LANE_CNT * LANE_BITS;

  typedef struct packed {
    logic                load;
    logic                advance;
    logic                doWrite;
    logic                doRead;
    logic [LANE_CNT-1:0] laneMask;
  } ramStrobes_t;
endpackage

// File: rtl/burstAddrGen.sv
module burstAddrGen #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic              linearBurst,
  input  logic [ADDR_W-1:0] loadAddr,
  output logic [ADDR_W-1:0] accAddr
);
  logic [ADDR_W-1:0] baseQ, baseNext;
  logic [1:0]        stepQ, stepNext, lowBits;

  always_comb begin
    baseNext = load ? loadAddr : baseQ;
    if (load)         stepNext = 2'd0;
    else if (advance) stepNext = stepQ + 2'd1;
    else              stepNext = stepQ;
    lowBits = linearBurst ? (baseNext[1:0] + stepNext) : (baseNext[1:0] ^ stepNext);
    accAddr = {baseNext[ADDR_W-1:2], lowBits};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      baseQ <= '0;
      stepQ <= '0;
    end else begin
      baseQ <= baseNext;
      stepQ <= stepNext;
    end
  end

  // R8: an advance steps the burst counter by exactly one
  assert_step_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load) |=> (stepQ == $past(stepQ) + 2'd1));

  // R10: without load or advance the burst position is frozen
  assert_hold_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !load) |=> ($stable(stepQ) && $stable(baseQ)));
endmodule

// File: rtl/burstRamCtrl.sv
module burstRamCtrl
  import burstRamPkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                zz,
  input  logic                cs1_n,
  input  logic                cs2,
  input  logic                cs3_n,
  input  logic                adsp_n,
  input  logic                adsc_n,
  input  logic                adv_n,
  input  logic                gw_n,
  input  logic                bw_n,
  input  logic [LANE_CNT-1:0] be_n,
  output ramStrobes_t         strb
);
  logic activeQ;
  logic adspHit, strobeHit, selected, writeReq, go;
  logic [LANE_CNT-1:0] lanes;

  always_comb begin
    adspHit   = !adsp_n && !cs1_n;
    strobeHit = adspHit || !adsc_n;
    selected  = !cs1_n && cs2 && !cs3_n;
    writeReq  = !gw_n || (!bw_n && (be_n != '1));
    lanes     = !gw_n ? '1 : (!bw_n ? ~be_n : '0);
    go        = !zz && (strobeHit ? selected : activeQ);

    strb.load     = !zz && strobeHit && selected;
    strb.advance  = !zz && !strobeHit && activeQ && !adv_n;
    strb.doWrite  = go && !adspHit && writeReq;
    strb.doRead   = go && (adspHit || !writeReq);
    strb.laneMask = strb.doWrite ? lanes : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                activeQ <= 1'b0;
    else if (!zz && strobeHit) activeQ <= selected;
  end

  // R2: an address load only happens with all three enables asserted
  assert_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strb.load |-> (!cs1_n && cs2 && !cs3_n));

  // R3: a global write reaches every lane
  assert_global_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.doWrite && !gw_n) |-> (&strb.laneMask));

  // R5: a primary-strobe cycle never writes
  assert_adsp_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsp_n && !cs1_n) |-> !strb.doWrite);

  // R12: sleep blocks every operation
  assert_sleep_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    zz |-> !(strb.load || strb.advance || strb.doWrite || strb.doRead));
endmodule

// File: rtl/burstRamData.sv
module burstRamData
  import burstRamPkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 zz,
  input  logic                 pipeMode,
  input  logic                 g_n,
  input  ramStrobes_t          strb,
  input  logic [ADDR_W-1:0]    accAddr,
  input  logic [WORD_BITS-1:0] dataIn,
  output logic [WORD_BITS-1:0] dataOut,
  output logic                 dataOutEn
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0]    rdAddrQ;
  logic                 rdValidQ, pipeValidQ;
  logic [WORD_BITS-1:0] flowWord, pipeDataQ;
  logic                 srcValid;

  for (genvar l = 0; l < LANE_CNT; l++) begin : gLane
    logic [LANE_BITS-1:0] laneMem [DEPTH];
    always_ff @(posedge clk) begin
      if (strb.doWrite && strb.laneMask[l])
        laneMem[accAddr] <= dataIn[l*LANE_BITS +: LANE_BITS];
    end
    assign flowWord[l*LANE_BITS +: LANE_BITS] = laneMem[rdAddrQ];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdValidQ   <= 1'b0;
      pipeValidQ <= 1'b0;
      rdAddrQ    <= '0;
      pipeDataQ  <= '0;
    end else if (!zz) begin
      rdValidQ   <= strb.doRead && !strb.doWrite;
      if (strb.load || strb.advance || strb.doRead) rdAddrQ <= accAddr;
      pipeValidQ <= rdValidQ;
      pipeDataQ  <= flowWord;
    end
  end

  always_comb begin
    srcValid  = pipeMode ? pipeValidQ : rdValidQ;
    dataOutEn = srcValid && !g_n && !zz;
    dataOut   = dataOutEn ? (pipeMode ? pipeDataQ : flowWord) : '0;
  end

  // R11: output enable high or sleep forces the bus off
  assert_oe_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (g_n || zz) |-> (!dataOutEn && dataOut == '0));

  // R7: a read word reaches the pipelined stage one cycle later
  assert_pipe_lag_R7: assert property (@(posedge clk) disable iff (!rst_n || zz)
    rdValidQ |=> pipeValidQ);
endmodule

// File: rtl/syncBurstRam.sv
module syncBurstRam
  import burstRamPkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [WORD_BITS-1:0] dataIn,
  input  logic                 cs1_n,
  input  logic                 cs2,
  input  logic                 cs3_n,
  input  logic                 adsp_n,
  input  logic                 adsc_n,
  input  logic                 adv_n,
  input  logic                 gw_n,
  input  logic                 bw_n,
  input  logic [LANE_CNT-1:0]  be_n,
  input  logic                 g_n,
  input  logic                 zz,
  input  logic                 pipeMode,
  input  logic                 linearBurst,
  output logic [WORD_BITS-1:0] dataOut,
  output logic                 dataOutEn
);
  ramStrobes_t       strb;
  logic [ADDR_W-1:0] accAddr;

  burstRamCtrl uCtrl (
    .clk(clk), .rst_n(rst_n), .zz(zz),
    .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
    .gw_n(gw_n), .bw_n(bw_n), .be_n(be_n),
    .strb(strb)
  );

  burstAddrGen #(.ADDR_W(ADDR_W)) uBurst (
    .clk(clk), .rst_n(rst_n),
    .load(strb.load), .advance(strb.advance),
    .linearBurst(linearBurst), .loadAddr(addr),
    .accAddr(accAddr)
  );

  burstRamData #(.ADDR_W(ADDR_W)) uData (
    .clk(clk), .rst_n(rst_n), .zz(zz), .pipeMode(pipeMode), .g_n(g_n),
    .strb(strb), .accAddr(accAddr), .dataIn(dataIn),
    .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

  // R13: a deselecting strobe silences a flow-through output next cycle
  assert_deselect_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!zz && (!adsc_n || (!adsp_n && !cs1_n)) && !(!cs1_n && cs2 && !cs3_n))
      |=> (pipeMode || !dataOutEn));

  // R12: the output never drives during sleep
  assert_sleep_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    zz |-> !dataOutEn);
endmodule

// File: tb/syncBurstRam_test.sv
module syncBurstRam_test;
  localparam int AW = 6;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] addr;
  logic [35:0] dataIn;
  logic cs1_n, cs2, cs3_n, adsp_n, adsc_n, adv_n, gw_n, bw_n, g_n, zz, pipeMode, linearBurst;
  logic [3:0] be_n;
  logic [35:0] dataOut;
  logic dataOutEn;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  logic [35:0] model [NW];

  syncBurstRam #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .dataIn(dataIn),
    .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
    .gw_n(gw_n), .bw_n(bw_n), .be_n(be_n),
    .g_n(g_n), .zz(zz), .pipeMode(pipeMode), .linearBurst(linearBurst),
    .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

  always #10 clk = ~clk;

  function automatic logic [35:0] pat(int a, int s);
    logic [35:0] w;
    for (int l = 0; l < 4; l++) w[l*9 +: 9] = 9'((a * 13 + s * 71 + l * 3) & 511);
    return w;
  endfunction

  task automatic idle();
    adsp_n = 1; adsc_n = 1; adv_n = 1; gw_n = 1; bw_n = 1; be_n = 4'hF;
    cs1_n = 0; cs2 = 1; cs3_n = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(string tag, logic expEn, logic [35:0] expData);
    tests++;
    if (dataOutEn !== expEn || (expEn && dataOut !== expData)) begin
      fails++;
      $display("FAIL %s: en=%0b data=%h expected en=%0b data=%h", tag, dataOutEn, dataOut, expEn, expData);
    end
  endtask

  task automatic writeAll(int a, logic [35:0] d);
    idle(); adsc_n = 0; gw_n = 0; addr = AW'(a); dataIn = d;
    step(); model[a] = d; idle();
  endtask

  task automatic readAt(int a);
    idle(); adsc_n = 0; addr = AW'(a); step(); idle();
  endtask

  task automatic flowCheck(string tag, int a);
    readAt(a); check(tag, 1'b1, model[a]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: en=%0b data=%h expected en=0 data=0", dataOutEn, dataOut);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle(); addr = '0; dataIn = '0; g_n = 0; zz = 0; pipeMode = 0; linearBurst = 1;
    repeat (3) step();
    rst_n = 1; step();
    check("R14 reset state", 1'b0, 36'h0);

    // R3: fill every word with global writes
    for (int a = 0; a < NW; a++) writeAll(a, pat(a, 0));

    // R6 / R1: flow-through back-to-back reads, alternating strobes
    for (int a = 0; a < NW; a++) begin
      idle(); addr = AW'(a);
      if (a % 2 == 0) adsp_n = 0; else adsc_n = 0;
      step();
      check("R6 flow read", 1'b1, model[a]);
    end

    // R7: pipelined back-to-back reads
    idle(); pipeMode = 1; step(); step();
    for (int a = 0; a < NW; a++) begin
      idle(); adsc_n = 0; addr = AW'(a); step();
      if (a > 0) check("R7 pipe read", 1'b1, model[a-1]);
    end
    idle(); step();
    check("R7 pipe last word", 1'b1, model[NW-1]);
    step();
    check("R10 pipe hold", 1'b1, model[NW-1]);
    pipeMode = 0;

    // R4 / R3: byte-lane masks, then global write overriding lane enables
    for (int m = 0; m < 16; m++) begin
      logic [35:0] d;
      d = pat(m, 1);
      idle(); adsc_n = 0; bw_n = 0; be_n = ~4'(m); addr = AW'(m); dataIn = d;
      step();
      for (int l = 0; l < 4; l++) if (m[l]) model[m][l*9 +: 9] = d[l*9 +: 9];
    end
    idle(); adsc_n = 0; gw_n = 0; bw_n = 0; be_n = 4'hF; addr = AW'(16); dataIn = pat(16, 2);
    step(); model[16] = pat(16, 2);
    for (int m = 0; m < 16; m++) flowCheck("R4 lane merge", m);
    flowCheck("R3 global overrides lane enables", 16);

    // R8 / R9: bursts from every start offset in both orders
    for (int lin = 0; lin < 2; lin++) begin
      for (int s = 0; s < 4; s++) begin
        int base;
        base = 32 + s;
        linearBurst = lin[0];
        flowCheck(lin == 1 ? "R8 burst first" : "R9 burst first", base);
        for (int n = 1; n < 4; n++) begin
          int ea;
          ea = 32 + (lin == 1 ? ((s + n) & 3) : (s ^ n));
          idle(); adv_n = 0; step();
          check(lin == 1 ? "R8 linear burst" : "R9 interleaved burst", 1'b1, model[ea]);
        end
      end
    end
    linearBurst = 1;

    // R10: suspended burst repeats the word
    flowCheck("R10 load", 40);
    idle(); step(); check("R10 hold 1", 1'b1, model[40]);
    step(); check("R10 hold 2", 1'b1, model[40]);

    // R5: primary strobe is a read even with write control low, write follows
    idle(); adsp_n = 0; gw_n = 0; addr = AW'(50); dataIn = pat(7, 9); step();
    check("R5 adsp cycle reads", 1'b1, model[50]);
    idle(); adv_n = 0; gw_n = 0; dataIn = pat(8, 9); step();
    model[51] = pat(8, 9);
    check("R5 write cycle not driven", 1'b0, 36'h0);
    flowCheck("R5 follow-on write", 51);
    flowCheck("R5 start word untouched", 50);

    // R1: primary strobe with cs1_n high is ignored, burst continues
    flowCheck("R1 load", 10);
    idle(); adsp_n = 0; cs1_n = 1; addr = AW'(11); step();
    check("R1 gated adsp ignored", 1'b1, model[10]);

    // R2: every enable combination
    for (int c = 0; c < 8; c++) begin
      idle(); adsc_n = 0; addr = AW'(5); cs1_n = c[2]; cs2 = c[1]; cs3_n = c[0];
      step();
      check("R2 select combo", (c == 2) ? 1'b1 : 1'b0, model[5]);
    end
    idle(); adsc_n = 0; gw_n = 0; cs2 = 0; addr = AW'(6); dataIn = pat(3, 5); step();
    flowCheck("R2 deselected write blocked", 6);

    // R13: single-cycle deselect, flow and pipelined
    flowCheck("R13 flow load", 7);
    idle(); adsc_n = 0; cs2 = 0; step();
    check("R13 flow off", 1'b0, 36'h0);
    pipeMode = 1;
    readAt(7);
    idle(); adsc_n = 0; cs2 = 0; step();
    check("R13 pipe last word", 1'b1, model[7]);
    idle(); step();
    check("R13 pipe off", 1'b0, 36'h0);
    pipeMode = 0;

    // R11: asynchronous output enable
    flowCheck("R11 load", 33);
    g_n = 1; #2; check("R11 g_n high", 1'b0, 36'h0);
    g_n = 0; #2; check("R11 g_n low", 1'b1, model[33]);

    // R12: sleep ignores writes, retains data, resumes
    flowCheck("R12 load", 20);
    zz = 1; #2; check("R12 asleep quiet", 1'b0, 36'h0);
    idle(); adsc_n = 0; gw_n = 0; addr = AW'(20); dataIn = pat(1, 13);
    step(); step();
    idle(); zz = 0; #2;
    check("R12 resume", 1'b1, model[20]);
    flowCheck("R12 retained", 20);

    // R14: reset keeps the array
    writeAll(60, pat(60, 4));
    flowCheck("R14 before reset", 60);
    rst_n = 0; step();
    check("R14 reset clears output", 1'b0, 36'h0);
    rst_n = 1; idle(); step();
    check("R14 idle after reset", 1'b0, 36'h0);
    flowCheck("R14 array kept", 60);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule